// File: doc/BRIEF.md
# Memory-controller event counter bank

This block is a bank of ten 32-bit performance counters for a memory controller. Each counter watches one bit of an event vector, chosen by a 5-bit select field. The select can be inverted. A counter advances only when a 64-bit qualifier input agrees with that counter's match value on every bit its mask enables. Each step adds either one or the value on a 4-bit magnitude input.

Counters 0 to 7 form the slow group. They see the slow event vector and advance only on cycles where the half-rate enable is high. Counters 8 and 9 form the fast group. They see the fast event vector and may advance on every clock. When a counter wraps, it sets a sticky bit in its group's overflow word. The interrupt output stays high while any such bit is set.

Software reaches every register through one 32-bit write port and one registered read port. There is no global stop: each counter is started and stopped through its own control register.

Top module: `evc_bank`

## Requirements
- R1: After a synchronous reset, every register reads zero and `irq` is low.
- R2: Byte addresses: counter n occupies 0x10 + 0x28*n onward, with mask bits 31:0 at +0x0, mask bits 63:32 at +0x4, match bits 31:0 at +0x8, match bits 63:32 at +0xC, control (9 bits, upper bits read zero) at +0x10 and value at +0x20. The slow-group overflow word is at 0x8 (bit n for counter n) and the fast-group word is at 0xC (bit 0 for counter 8, bit 1 for counter 9). `reg_rdata` shows the register at the `reg_addr` of the previous cycle. Every other address reads zero, and writes to other addresses have no effect.
- R3: Control bit 0 enables counting and bits 6:2 select the event. Select 0 counts every eligible cycle. Select k>0 counts the cycles where bit k of the group's event vector is high.
- R4: A counter advances only when (qual & mask) == (match & mask). An all-zero mask always qualifies.
- R5: Control bits 8:7 give the increment mode. Mode 1 adds `ev_mag` per counted cycle; modes 0, 2 and 3 add one.
- R6: Slow-group counters advance only on cycles with `half_en` high. Fast-group counters ignore `half_en`.
- R7: The value wraps modulo 2^32, and a carry out of bit 31 sets that counter's overflow bit.
- R8: Overflow bits are sticky. Writing zero to an overflow word clears it, and a non-zero write to it is ignored. An overflow in the same cycle as a clear leaves its bit set.
- R9: `irq` is the OR of all overflow bits, one cycle after them.
- R10: Clearing the enable bit freezes the value. A software write to the value in a cycle where the counter would advance loads the written value with no increment.
- R11: Control bit 1 inverts the selected event, so an inverted cycle count never advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_en | input | 1 | Half-rate enable for counters 0 to 7 |
| ev_half | input | 32 | Event vector for the slow group |
| ev_full | input | 32 | Event vector for the fast group |
| ev_mag | input | 4 | Increment magnitude for mode 1 |
| qual | input | 64 | Qualifier compared through mask and match |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 10 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Overflow interrupt, registered |

## Verification
The event select is swept over all 32 codes, with and without inversion, on a burst of three low then five high cycles. The two polarities then give distinct counts, and this separates the cycle-count code from wrong bit picks and from a missing inversion.

The increment modes are crossed with magnitudes 0, 1, 7 and 15, which tells mode 1 apart from the reserved modes. Qualification is tried with a single-bit mask at positions in both 32-bit halves, against matching and non-matching qualifiers.

The half-rate enable is toggled on every counter of the slow group. Wraps are driven from preloaded values near the top, including a wrap in the same cycle as a status clear.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int REG_W    = 32;
  localparam int CNT_W    = 32;
  localparam int QUAL_W   = 64;
  localparam int SEL_W    = 5;
  localparam int EV_W     = 2 ** SEL_W;
  localparam int CTRL_W   = 9;

  localparam int GRP_BASE   = 'h10;
  localparam int GRP_STRIDE = 'h28;
  localparam int GRP_SPAN   = 'h28;
  localparam int ST_HALF_A  = 'h8;
  localparam int ST_FULL_A  = 'hC;

  localparam int OFS_MSK_LO = 'h00;
  localparam int OFS_MSK_HI = 'h04;
  localparam int OFS_MAT_LO = 'h08;
  localparam int OFS_MAT_HI = 'h0C;
  localparam int OFS_CTRL   = 'h10;
  localparam int OFS_VALUE  = 'h20;

  typedef enum logic [1:0] {
    INC_ONE  = 2'd0,
    INC_MAG  = 2'd1,
    INC_RSV2 = 2'd2,
    INC_RSV3 = 2'd3
  } inc_mode_e;

  // first member is the MSB: bits 8:7 mode, 6:2 select, 1 invert, 0 enable
  typedef struct packed {
    inc_mode_e        inc;
    logic [SEL_W-1:0] sel;
    logic             inv;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/evc_counter.sv
module evc_counter
  import evc_pkg::*;
#(
  parameter int AW   = 10,
  parameter int MW   = 4,
  parameter int BASE = 'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [AW-1:0]     rd_addr,
  input  logic [EV_W-1:0]   ev,
  input  logic [MW-1:0]     mag,
  input  logic [QUAL_W-1:0] qual,
  output logic [REG_W-1:0]  rd_data,
  output logic              ovf
);
  localparam logic [AW-1:0] LO_A = AW'(BASE);
  localparam logic [AW-1:0] HI_A = AW'(BASE + GRP_SPAN);

  logic [QUAL_W-1:0] mask_q, match_q;
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  cnt_q;

  logic              wr_hit, rd_hit;
  logic [AW-1:0]     wr_off, rd_off;
  logic              wr_val;
  logic              ev_sel, active, qualified, step;
  logic [CNT_W-1:0]  inc;
  logic [CNT_W:0]    sum;

  assign wr_hit = wr_en && (wr_addr >= LO_A) && (wr_addr < HI_A);
  assign rd_hit = (rd_addr >= LO_A) && (rd_addr < HI_A);
  assign wr_off = wr_addr - LO_A;
  assign rd_off = rd_addr - LO_A;
  assign wr_val = wr_hit && (wr_off == AW'(OFS_VALUE));

  // event path: select 0 is a plain cycle count
  assign ev_sel    = (ctrl_q.sel == '0) ? 1'b1 : ev[ctrl_q.sel];
  assign active    = ev_sel ^ ctrl_q.inv;
  assign qualified = ((qual ^ match_q) & mask_q) == '0;
  assign step      = ctrl_q.en && tick && active && qualified;
  assign inc       = (ctrl_q.inc == INC_MAG) ? CNT_W'(mag) : CNT_W'(1);
  assign sum       = {1'b0, cnt_q} + {1'b0, inc};
  assign ovf       = step && !wr_val && sum[CNT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      match_q <= '0;
      ctrl_q  <= '0;
      cnt_q   <= '0;
    end else begin
      if (wr_hit) begin
        case (wr_off)
          AW'(OFS_MSK_LO): mask_q[REG_W-1:0]        <= wdata;
          AW'(OFS_MSK_HI): mask_q[QUAL_W-1:REG_W]   <= wdata;
          AW'(OFS_MAT_LO): match_q[REG_W-1:0]       <= wdata;
          AW'(OFS_MAT_HI): match_q[QUAL_W-1:REG_W]  <= wdata;
          AW'(OFS_CTRL):   ctrl_q                   <= ctrl_t'(wdata[CTRL_W-1:0]);
          default: ;
        endcase
      end
      if (wr_val)    cnt_q <= wdata;
      else if (step) cnt_q <= sum[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_hit) begin
      case (rd_off)
        AW'(OFS_MSK_LO): rd_data = mask_q[REG_W-1:0];
        AW'(OFS_MSK_HI): rd_data = mask_q[QUAL_W-1:REG_W];
        AW'(OFS_MAT_LO): rd_data = match_q[REG_W-1:0];
        AW'(OFS_MAT_HI): rd_data = match_q[QUAL_W-1:REG_W];
        AW'(OFS_CTRL):   rd_data = REG_W'(ctrl_q);
        AW'(OFS_VALUE):  rd_data = cnt_q;
        default:         rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/evc_ovf_status.sv
module evc_ovf_status
  import evc_pkg::*;
#(
  parameter int N    = 8,
  parameter int AW   = 10,
  parameter int ADDR = 'h8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [REG_W-1:0] wdata,
  input  logic [N-1:0]     set,
  output logic [N-1:0]     st
);
  logic clr;

  assign clr = wr_en && (wr_addr == AW'(ADDR)) && (wdata == '0);

  always_ff @(posedge clk) begin
    if (rst) st <= '0;
    else     st <= (clr ? '0 : st) | set;
  end
endmodule

// File: rtl/evc_bank.sv
module evc_bank
  import evc_pkg::*;
#(
  parameter int AW     = 10,
  parameter int N_HALF = 8,
  parameter int N_FULL = 2,
  parameter int MW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              half_en,
  input  logic [EV_W-1:0]   ev_half,
  input  logic [EV_W-1:0]   ev_full,
  input  logic [MW-1:0]     ev_mag,
  input  logic [QUAL_W-1:0] qual,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  localparam int N_TOT = N_HALF + N_FULL;

  logic [REG_W-1:0] rd_vec [N_TOT];
  logic [N_TOT-1:0] ovf_all;
  logic [N_HALF-1:0] ovf_h, st_h;
  logic [N_FULL-1:0] ovf_f, st_f;
  logic [REG_W-1:0] rd_mux;

  for (genvar i = 0; i < N_TOT; i++) begin : g_cnt
    logic            tick_i;
    logic [EV_W-1:0] ev_i;
    if (i < N_HALF) begin : g_half
      assign tick_i = half_en;
      assign ev_i   = ev_half;
    end else begin : g_full
      assign tick_i = 1'b1;
      assign ev_i   = ev_full;
    end
    evc_counter #(
      .AW  (AW),
      .MW  (MW),
      .BASE(GRP_BASE + GRP_STRIDE * i)
    ) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick_i),
      .wr_en  (reg_wr),
      .wr_addr(reg_addr),
      .wdata  (reg_wdata),
      .rd_addr(reg_addr),
      .ev     (ev_i),
      .mag    (ev_mag),
      .qual   (qual),
      .rd_data(rd_vec[i]),
      .ovf    (ovf_all[i])
    );
  end

  assign ovf_h = ovf_all[N_HALF-1:0];
  assign ovf_f = ovf_all[N_TOT-1:N_HALF];

  evc_ovf_status #(.N(N_HALF), .AW(AW), .ADDR(ST_HALF_A)) u_st_half (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_addr(reg_addr),
    .wdata(reg_wdata), .set(ovf_h), .st(st_h)
  );

  evc_ovf_status #(.N(N_FULL), .AW(AW), .ADDR(ST_FULL_A)) u_st_full (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_addr(reg_addr),
    .wdata(reg_wdata), .set(ovf_f), .st(st_f)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_TOT; i++) rd_mux = rd_mux | rd_vec[i];
    if (reg_addr == AW'(ST_HALF_A)) rd_mux = REG_W'(st_h);
    if (reg_addr == AW'(ST_FULL_A)) rd_mux = REG_W'(st_f);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      reg_rdata <= rd_mux;
      irq       <= |{st_h, st_f};
    end
  end
endmodule

// File: rtl/evc_bank_chk.sv
module evc_bank_chk #(
  parameter int AW     = 10,
  parameter int N_HALF = 8,
  parameter int N_FULL = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              half_en,
  input logic              reg_wr,
  input logic [AW-1:0]     reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              irq,
  input logic [N_HALF-1:0] st_h,
  input logic [N_FULL-1:0] st_f,
  input logic [N_HALF-1:0] ovf_h,
  input logic [N_FULL-1:0] ovf_f
);
  logic clr_h, clr_f;
  assign clr_h = reg_wr && (reg_addr == AW'('h8)) && (reg_wdata == '0);
  assign clr_f = reg_wr && (reg_addr == AW'('hC)) && (reg_wdata == '0);

  // R8
  sticky_half_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_h |=> ((st_h & $past(st_h)) == $past(st_h)));

  // R8
  sticky_full_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_f |=> ((st_f & $past(st_f)) == $past(st_f)));

  // R8
  clear_half_chk: assert property (@(posedge clk) disable iff (rst)
    clr_h |=> (st_h == $past(ovf_h)));

  // R7
  wrap_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (|ovf_f) |=> ((st_f & $past(ovf_f)) == $past(ovf_f)));

  // R6
  half_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !half_en |-> (ovf_h == '0));

  // R9
  irq_high_chk: assert property (@(posedge clk) disable iff (rst)
    (|{st_h, st_f}) |=> irq);

  // R9
  irq_low_chk: assert property (@(posedge clk) disable iff (rst)
    !(|{st_h, st_f}) |=> !irq);

  // R2
  unused_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == '0) |=> (reg_rdata == '0));
endmodule

bind evc_bank evc_bank_chk #(.AW(AW), .N_HALF(N_HALF), .N_FULL(N_FULL)) u_chk (
  .clk(clk), .rst(rst), .half_en(half_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
  .st_h(st_h), .st_f(st_f), .ovf_h(ovf_h), .ovf_f(ovf_f)
);

// File: tb/tb_evc_bank.sv
module tb_evc_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        half_en = 1'b0;
  logic [31:0] ev_half = '0;
  logic [31:0] ev_full = '0;
  logic [3:0]  ev_mag = '0;
  logic [63:0] qual = '0;
  logic        reg_wr = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  evc_bank dut (
    .clk(clk), .rst(rst), .half_en(half_en), .ev_half(ev_half), .ev_full(ev_full),
    .ev_mag(ev_mag), .qual(qual), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [9:0] cb(input int i);
    return 10'('h10 + 'h28 * i);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic cyc();
    @(negedge clk);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int offs [6] = '{'h0, 'h4, 'h8, 'hC, 'h10, 'h20};
    int gaps [4] = '{'h14, 'h18, 'h1C, 'h24};
    int bits [6] = '{0, 17, 31, 32, 45, 63};

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    for (int i = 0; i < 10; i++)
      for (int k = 0; k < 6; k++) begin
        rd(cb(i) + 10'(offs[k]), d);
        chk("R1 counter reg", d, 0);
      end
    rd(10'h8, d);  chk("R1 half status", d, 0);
    rd(10'hC, d);  chk("R1 full status", d, 0);

    // R2 register map sweep
    for (int i = 0; i < 10; i++)
      for (int k = 0; k < 6; k++)
        wr(cb(i) + 10'(offs[k]), {8'(i), 8'(offs[k]), 16'hA5C3} & ((k == 4) ? 32'h1FE : 32'hFFFF_FFFF));
    for (int i = 0; i < 10; i++) begin
      for (int k = 0; k < 6; k++) begin
        rd(cb(i) + 10'(offs[k]), d);
        chk("R2 readback", d, {8'(i), 8'(offs[k]), 16'hA5C3} & ((k == 4) ? 32'h1FE : 32'hFFFF_FFFF));
      end
      for (int k = 0; k < 4; k++) begin
        wr(cb(i) + 10'(gaps[k]), 32'hFFFF_FFFF);
        rd(cb(i) + 10'(gaps[k]), d);
        chk("R2 gap reads zero", d, 0);
      end
    end
    rd(10'h0, d);   chk("R2 addr 0x0", d, 0);
    rd(10'h4, d);   chk("R2 addr 0x4", d, 0);
    rd(10'h1A0, d); chk("R2 addr 0x1A0", d, 0);
    rd(10'h3FC, d); chk("R2 addr 0x3FC", d, 0);
    for (int i = 0; i < 10; i++)
      for (int k = 0; k < 6; k++) wr(cb(i) + 10'(offs[k]), 0);

    // R3 / R11 select and invert sweep on counter 8
    for (int inv = 0; inv < 2; inv++)
      for (int sel = 0; sel < 32; sel++) begin
        ev_full = '0;
        wr(cb(8) + 10'h20, 0);
        wr(cb(8) + 10'h10, 32'(1 | (inv << 1) | (sel << 2)));
        for (int j = 0; j < 8; j++) begin
          ev_full = (j < 3) ? ~(32'd1 << sel) : (32'd1 << sel);
          cyc();
        end
        wr(cb(8) + 10'h10, 0);
        rd(cb(8) + 10'h20, d);
        if (sel == 0) chk(inv ? "R11 inverted cycle count" : "R3 cycle count", d, inv ? 0 : 9);
        else          chk(inv ? "R11 inverted select" : "R3 select", d, inv ? 3 : 6);
      end
    ev_full = '0;

    // R5 increment modes on counter 9
    for (int m = 0; m < 4; m++)
      for (int g = 0; g < 4; g++) begin
        ev_mag = (g == 0) ? 4'd0 : (g == 1) ? 4'd1 : (g == 2) ? 4'd7 : 4'd15;
        wr(cb(9) + 10'h20, 0);
        wr(cb(9) + 10'h10, 32'(1 | (m << 7)));
        repeat (3) cyc();
        wr(cb(9) + 10'h10, 0);
        rd(cb(9) + 10'h20, d);
        chk("R5 increment mode", d, (m == 1) ? 32'(4 * ev_mag) : 32'd4);
      end

    // R4 qualification on counter 8
    for (int b = 0; b < 6; b++)
      for (int hit = 0; hit < 2; hit++) begin
        logic [63:0] mk;
        mk = 64'd1 << bits[b];
        qual = hit ? mk : ~mk;
        wr(cb(8) + 10'h0, mk[31:0]);  wr(cb(8) + 10'h4, mk[63:32]);
        wr(cb(8) + 10'h8, mk[31:0]);  wr(cb(8) + 10'hC, mk[63:32]);
        wr(cb(8) + 10'h20, 0);
        wr(cb(8) + 10'h10, 1);
        repeat (4) cyc();
        wr(cb(8) + 10'h10, 0);
        rd(cb(8) + 10'h20, d);
        chk("R4 mask/match", d, hit ? 5 : 0);
      end
    for (int k = 0; k < 4; k++) wr(cb(8) + 10'(offs[k]), 0);
    qual = 64'hDEAD_BEEF_1234_5678;
    wr(cb(8) + 10'h20, 0);
    wr(cb(8) + 10'h10, 1);
    repeat (4) cyc();
    wr(cb(8) + 10'h10, 0);
    rd(cb(8) + 10'h20, d);
    chk("R4 zero mask", d, 5);
    qual = '0;

    // R6 half-rate gating on all slow counters
    ev_half = '1;
    for (int i = 0; i < 8; i++) begin
      half_en = 1'b0;
      wr(cb(i) + 10'h20, 0);
      wr(cb(i) + 10'h10, 32'(1 | ((i + 1) << 2)));
      for (int j = 0; j < 8; j++) begin
        half_en = j[0];
        cyc();
      end
      wr(cb(i) + 10'h10, 0);
      rd(cb(i) + 10'h20, d);
      chk("R6 half-rate count", d, 5);
    end
    ev_half = '0;
    half_en = 1'b0;
    wr(cb(9) + 10'h20, 0);
    wr(cb(9) + 10'h10, 1);
    repeat (3) cyc();
    wr(cb(9) + 10'h10, 0);
    rd(cb(9) + 10'h20, d);
    chk("R6 fast group ignores half_en", d, 4);

    // R7 / R9 wrap on counter 2
    half_en = 1'b1;
    wr(cb(2) + 10'h20, 32'hFFFF_FFFE);
    wr(cb(2) + 10'h10, 1);
    cyc();
    wr(cb(2) + 10'h10, 0);
    @(negedge clk); chk("R9 irq lags status", 32'(irq), 0);
    @(negedge clk); chk("R9 irq raised", 32'(irq), 1);
    rd(cb(2) + 10'h20, d); chk("R7 wrapped value", d, 0);
    rd(10'h8, d);          chk("R7 half status bit", d, 32'h4);
    rd(10'hC, d);          chk("R7 full status clear", d, 0);
    wr(10'h8, 32'hFF);
    rd(10'h8, d);          chk("R8 non-zero write ignored", d, 32'h4);

    // R7 wrap with magnitude on counter 9
    ev_mag = 4'd3;
    wr(cb(9) + 10'h20, 32'hFFFF_FFFF);
    wr(cb(9) + 10'h10, 32'(1 | (1 << 7)));
    wr(cb(9) + 10'h10, 0);
    rd(cb(9) + 10'h20, d); chk("R7 wrap modulo", d, 2);
    rd(10'hC, d);          chk("R7 full status bit", d, 32'h2);

    // R8 / R9 clears
    wr(10'h8, 0);
    rd(10'h8, d);          chk("R8 half cleared", d, 0);
    rd(10'hC, d);          chk("R8 full untouched", d, 32'h2);
    chk("R9 irq still high", 32'(irq), 1);
    wr(10'hC, 0);
    @(negedge clk); chk("R9 irq one cycle after clear", 32'(irq), 1);
    @(negedge clk); chk("R9 irq dropped", 32'(irq), 0);

    // R8 overflow in the clear cycle wins
    wr(cb(8) + 10'h20, 32'hFFFF_FFFF);
    wr(cb(8) + 10'h10, 1);
    wr(10'hC, 0);
    wr(cb(8) + 10'h10, 0);
    rd(10'hC, d);          chk("R8 set beats clear", d, 32'h1);
    rd(cb(8) + 10'h20, d); chk("R8 count after wrap", d, 1);
    wr(10'hC, 0);

    // R10 disable freezes, write beats count
    wr(cb(5) + 10'h20, 100);
    wr(cb(5) + 10'h10, 1);
    repeat (3) cyc();
    wr(cb(5) + 10'h10, 0);
    repeat (5) cyc();
    rd(cb(5) + 10'h20, d); chk("R10 frozen value", d, 104);
    wr(cb(9) + 10'h20, 0);
    wr(cb(9) + 10'h10, 1);
    wr(cb(9) + 10'h20, 50);
    wr(cb(9) + 10'h10, 0);
    rd(cb(9) + 10'h20, d); chk("R10 write priority", d, 51);
    chk("R9 irq idle", 32'(irq), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule